// File: doc/BRIEF.md
# Split-Byte Access Bridge for a Wide Register

This block lets a narrow byte-wide bus reach a word register that is twice as wide. The two halves never come apart during an access. A single temporary byte sits between the bus and the upper half of the word.

For a read, the bus fetches the lower byte first. In that same cycle the upper byte is frozen into the temporary byte. A later read of the upper address then returns that frozen copy. This holds even if the peripheral has reloaded the word in the meantime.

For a write, the bus places the upper byte first, and it lands only in the temporary byte. The write of the lower byte then joins the bus data with the temporary byte and loads the whole word on one clock edge. Whole-word writes are accepted only while a permission input is high. Separately, the peripheral side can load the word at any time through its own strobe.

Top module: `wide_reg_bridge`

## Requirements
- R1: While reset is asserted (active low, asynchronous), the word reads 0x0000, the temporary byte holds 0x00 and the bus read data is 0x00.
- R2: A read strobe at the low address (0) returns the word's lower byte on the read data, valid from the first rising edge after the strobe cycle.
- R3: A low-address read copies the word's upper byte into the temporary byte on the same edge that delivers the lower byte.
- R4: A read strobe at the high address (1) returns the temporary byte one edge later. This holds even after the peripheral reloaded the word between the low read and the high read.
- R5: A write at the high address stores the bus data in the temporary byte only. The word output does not change.
- R6: A write at the low address while permission is high loads the word with {temporary byte, bus data} on a single edge.
- R7: A write at the low address while permission is low leaves the word unchanged. A high-address write while permission is low still loads the temporary byte.
- R8: A peripheral load strobe replaces the word with the peripheral value on the next edge. If a permitted low-address write falls in the same cycle, the bus commit wins.
- R9: Bus read data holds its last value in every cycle without a read strobe.
- R10: Accesses to addresses other than 0 and 1 change neither the word, the temporary byte nor the read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W (2) | Byte address: 0 lower byte, 1 upper byte |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | BYTE_W (8) | Write data |
| bus_rdata | output | BYTE_W (8) | Registered read data |
| wr_allow | input | 1 | Permission for whole-word bus writes |
| hw_load | input | 1 | Peripheral load strobe |
| hw_value | input | 2*BYTE_W (16) | Peripheral value for the word |
| reg_value | output | 2*BYTE_W (16) | Current word |

## Verification
Every result in this block lands one rising edge after the cycle that carries its strobe. This covers read data, temporary-byte loads, word commits and peripheral loads. The bench drives each strobe on a falling edge and removes it at the next falling edge. It then samples the outputs at that same falling edge, half a period after the single edge that acts on the strobe. The temporary byte has no port. The bench therefore observes it through a later high-address read, or through a later permitted low write that exposes it in the upper byte of the word.

// File: rtl/wide_reg_bridge_pkg.sv
package wide_reg_bridge_pkg;

   // Decoded single-cycle bus actions
   typedef struct packed {
      logic rd_lo;    // read lower byte, snapshot upper
      logic rd_hi;    // read temporary byte
      logic ld_tmp;   // load temporary byte from bus
      logic commit;   // permitted lower write: load whole word
   } bus_act_t;

   typedef enum logic [1:0] {
      RD_HOLD_LAST = 2'd0,
      RD_ZERO_IDLE = 2'd1
   } rd_idle_e;

endpackage

// File: rtl/wrb_decode.sv
module wrb_decode
   import wide_reg_bridge_pkg::*;
#(
   parameter int ADDR_W  = 2,
   parameter int LO_ADDR = 0,
   parameter int HI_ADDR = 1
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              rd,
   input  logic              wr,
   input  logic              allow,
   output bus_act_t          act
);
   localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(LO_ADDR);
   localparam logic [ADDR_W-1:0] HI_A = ADDR_W'(HI_ADDR);

   logic hit_lo, hit_hi;

   always_comb begin
      hit_lo     = (addr == LO_A);
      hit_hi     = (addr == HI_A);
      act.rd_lo  = rd & hit_lo;
      act.rd_hi  = rd & hit_hi;
      act.ld_tmp = wr & hit_hi;
      act.commit = wr & hit_lo & allow;
   end
endmodule

// File: rtl/wrb_temp.sv
module wrb_temp #(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              snap,
   input  logic [BYTE_W-1:0] snap_val,
   input  logic              load,
   input  logic [BYTE_W-1:0] load_val,
   output logic [BYTE_W-1:0] tmp
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    tmp <= '0;
      else if (load) tmp <= load_val;
      else if (snap) tmp <= snap_val;
   end
endmodule

// File: rtl/wrb_word.sv
module wrb_word #(
   parameter int BYTE_W = 8,
   parameter logic [2*BYTE_W-1:0] RESET_VAL = '0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                commit,
   input  logic [2*BYTE_W-1:0] commit_val,
   input  logic                hw_load,
   input  logic [2*BYTE_W-1:0] hw_val,
   output logic [2*BYTE_W-1:0] word
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       word <= RESET_VAL;
      else if (commit)  word <= commit_val;
      else if (hw_load) word <= hw_val;
   end
endmodule

// File: rtl/wrb_rdport.sv
module wrb_rdport
   import wide_reg_bridge_pkg::*;
#(
   parameter int       BYTE_W  = 8,
   parameter rd_idle_e IDLE_MD = RD_HOLD_LAST
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_lo,
   input  logic              rd_hi,
   input  logic [BYTE_W-1:0] lo_byte,
   input  logic [BYTE_W-1:0] tmp,
   output logic [BYTE_W-1:0] rdata
);
   logic [BYTE_W-1:0] idle_val;

   generate
      if (IDLE_MD == RD_ZERO_IDLE) begin : g_zero
         always_comb idle_val = '0;
      end else begin : g_hold
         always_comb idle_val = rdata;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rdata <= '0;
      else if (rd_lo) rdata <= lo_byte;
      else if (rd_hi) rdata <= tmp;
      else            rdata <= idle_val;
   end
endmodule

// File: rtl/wide_reg_bridge.sv
module wide_reg_bridge
   import wide_reg_bridge_pkg::*;
#(
   parameter int       BYTE_W    = 8,
   parameter int       ADDR_W    = 2,
   parameter int       LO_ADDR   = 0,
   parameter int       HI_ADDR   = 1,
   parameter rd_idle_e IDLE_MD   = RD_HOLD_LAST,
   parameter logic [2*BYTE_W-1:0] RESET_VAL = '0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic                bus_rd,
   input  logic                bus_wr,
   input  logic [BYTE_W-1:0]   bus_wdata,
   output logic [BYTE_W-1:0]   bus_rdata,
   input  logic                wr_allow,
   input  logic                hw_load,
   input  logic [2*BYTE_W-1:0] hw_value,
   output logic [2*BYTE_W-1:0] reg_value
);
   localparam int WORD_W = 2 * BYTE_W;

   // Elaboration-time parameter checks
   generate
      if (BYTE_W < 1) begin : g_bad_byte
         $error("BYTE_W must be at least 1");
      end
      if (LO_ADDR == HI_ADDR) begin : g_bad_addr
         $error("LO_ADDR and HI_ADDR must differ");
      end
      if (LO_ADDR >= (1 << ADDR_W) || HI_ADDR >= (1 << ADDR_W)) begin : g_bad_range
         $error("addresses must fit in ADDR_W bits");
      end
   endgenerate

   bus_act_t           act;
   logic [BYTE_W-1:0]  tmp;

   wrb_decode #(.ADDR_W(ADDR_W), .LO_ADDR(LO_ADDR), .HI_ADDR(HI_ADDR)) u_dec (
      .addr(bus_addr), .rd(bus_rd), .wr(bus_wr), .allow(wr_allow), .act(act)
   );

   wrb_temp #(.BYTE_W(BYTE_W)) u_tmp (
      .clk(clk), .rst_n(rst_n),
      .snap(act.rd_lo), .snap_val(reg_value[WORD_W-1:BYTE_W]),
      .load(act.ld_tmp), .load_val(bus_wdata),
      .tmp(tmp)
   );

   wrb_word #(.BYTE_W(BYTE_W), .RESET_VAL(RESET_VAL)) u_word (
      .clk(clk), .rst_n(rst_n),
      .commit(act.commit), .commit_val({tmp, bus_wdata}),
      .hw_load(hw_load), .hw_val(hw_value),
      .word(reg_value)
   );

   wrb_rdport #(.BYTE_W(BYTE_W), .IDLE_MD(IDLE_MD)) u_rd (
      .clk(clk), .rst_n(rst_n),
      .rd_lo(act.rd_lo), .rd_hi(act.rd_hi),
      .lo_byte(reg_value[BYTE_W-1:0]), .tmp(tmp),
      .rdata(bus_rdata)
   );

   // Assertions
   localparam logic [ADDR_W-1:0] A_LO = ADDR_W'(LO_ADDR);
   localparam logic [ADDR_W-1:0] A_HI = ADDR_W'(HI_ADDR);

   a_r2_low_read_data: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == A_LO) |=> bus_rdata == $past(reg_value[BYTE_W-1:0]));

   a_r3_snapshot: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == A_LO && !bus_wr) |=> tmp == $past(reg_value[WORD_W-1:BYTE_W]));

   a_r4_high_read_tmp: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == A_HI) |=> bus_rdata == $past(tmp));

   a_r5_tmp_load: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == A_HI) |=> tmp == $past(bus_wdata));

   a_r5_word_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == A_HI && !hw_load) |=> $stable(reg_value));

   a_r6_commit: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == A_LO && wr_allow) |=> reg_value == {$past(tmp), $past(bus_wdata)});

   a_r7_blocked: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == A_LO && !wr_allow && !hw_load) |=> $stable(reg_value));

   a_r8_hw_load: assert property (@(posedge clk) disable iff (!rst_n)
      (hw_load && !(bus_wr && bus_addr == A_LO && wr_allow)) |=> reg_value == $past(hw_value));

   a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_rd && IDLE_MD == RD_HOLD_LAST) |=> $stable(bus_rdata));
endmodule

// File: tb/tb_wide_reg_bridge.sv
module tb_wide_reg_bridge;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  bus_addr = '0;
   logic        bus_rd = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic        wr_allow = 1'b0;
   logic        hw_load = 1'b0;
   logic [15:0] hw_value = '0;
   logic [15:0] reg_value;

   int checks = 0;
   int fails  = 0;

   always #4 clk = ~clk;

   wide_reg_bridge dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
      .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .wr_allow(wr_allow), .hw_load(hw_load), .hw_value(hw_value),
      .reg_value(reg_value)
   );

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic do_read(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk); bus_addr = a; bus_rd = 1'b1;
      @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
   endtask

   task automatic do_write(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk); bus_wr = 1'b0;
   endtask

   task automatic do_hw(input logic [15:0] v);
      @(negedge clk); hw_value = v; hw_load = 1'b1;
      @(negedge clk); hw_load = 1'b0;
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [7:0] d;
      logic [7:0] last;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 word", reg_value, 16'h0000);
      chk("R1 rdata", {8'h00, bus_rdata}, 16'h0000);
      rst_n = 1'b1;
      do_read(2'd1, d);
      chk("R1 tmp", {8'h00, d}, 16'h0000);

      // R6/R2/R3/R4/R5 sweep: write word, read it back in order
      wr_allow = 1'b1;
      for (int i = 0; i < 48; i++) begin
         logic [15:0] w;
         w = 16'((i * 16'd2731) ^ (i << 11) ^ 16'h5a3c);
         do_write(2'd1, w[15:8]);
         chk("R5 word unchanged after high write", reg_value, (i == 0) ? 16'h0000 : last_word(i - 1));
         do_write(2'd0, w[7:0]);
         chk("R6 commit", reg_value, w);
         do_read(2'd0, d);
         chk("R2 low read", {8'h00, d}, {8'h00, w[7:0]});
         do_read(2'd1, d);
         chk("R3/R4 high read", {8'h00, d}, {8'h00, w[15:8]});
      end

      // R4: snapshot survives peripheral update
      for (int i = 0; i < 16; i++) begin
         logic [15:0] a, b;
         a = 16'(16'h1234 + i * 16'h0f13);
         b = ~a;
         do_hw(a);
         chk("R8 hw load", reg_value, a);
         do_read(2'd0, d);
         chk("R2 low read after hw", {8'h00, d}, {8'h00, a[7:0]});
         do_hw(b);
         do_read(2'd1, d);
         chk("R4 snapshot kept", {8'h00, d}, {8'h00, a[15:8]});
         chk("R8 live word", reg_value, b);
      end

      // R7: blocked low write, high write still loads tmp
      do_hw(16'hbeef);
      wr_allow = 1'b0;
      do_write(2'd1, 8'h3c);
      do_write(2'd0, 8'h77);
      chk("R7 blocked commit", reg_value, 16'hbeef);
      wr_allow = 1'b1;
      do_write(2'd0, 8'h99);
      chk("R7 tmp loaded while blocked", reg_value, 16'h3c99);

      // R8: bus commit wins over simultaneous hw load
      do_write(2'd1, 8'hc4);
      @(negedge clk);
      bus_addr = 2'd0; bus_wdata = 8'h21; bus_wr = 1'b1;
      hw_value = 16'h0f0f; hw_load = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0; hw_load = 1'b0;
      chk("R8 commit precedence", reg_value, 16'hc421);

      // R9: read data holds without strobe
      do_read(2'd0, d);
      last = d;
      do_hw(16'h5500);
      repeat (4) @(negedge clk);
      chk("R9 rdata hold", {8'h00, bus_rdata}, {8'h00, last});

      // R10: unmapped addresses have no effect
      do_write(2'd1, 8'haa);
      do_write(2'd2, 8'h55);
      do_write(2'd3, 8'h66);
      chk("R10 word after unmapped write", reg_value, 16'h5500);
      do_read(2'd2, d);
      chk("R10 rdata after unmapped read", {8'h00, d}, {8'h00, last});
      do_read(2'd3, d);
      chk("R10 rdata after unmapped read 3", {8'h00, d}, {8'h00, last});
      do_write(2'd0, 8'h11);
      chk("R10 tmp kept", reg_value, 16'haa11);

      // R1: reset again clears everything
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk);
      chk("R1 word in reset", reg_value, 16'h0000);
      chk("R1 rdata in reset", {8'h00, bus_rdata}, 16'h0000);
      finish_run();
   end

   function automatic logic [15:0] last_word(input int i);
      return 16'((i * 16'd2731) ^ (i << 11) ^ 16'h5a3c);
   endfunction
endmodule